// File: doc/BRIEF.md
# Vector Element Unzip Permute Unit

This unit takes two source vectors of equal length and de-interleaves them into a single destination vector. Both operands are split into elements of a width chosen at run time. Every second element is picked, starting at index 0 for the even part or index 1 for the odd part. The picks from the first operand are packed contiguously into the lower half of the result, and the picks from the second operand into the upper half. The vector length is a build-time parameter. The element width comes from a two-bit size code, or is fixed at 128 bits when the wide-form flag is set.

The unit is fully pipelined with a single register stage. Each valid strobe yields one result cycle later. If the vector length cannot hold two elements of the selected width, the request is flagged as undefined and the result is forced to zero. This case can only arise for the 128-bit form when the vector length is 128.

Top module: `vec_unzip_unit`

## Requirements
- R1: The element width is 8 << size_code (code 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) when wide_form is 0. When wide_form is 1 the width is 128 bits and size_code has no effect.
- R2: With pairs = VL / (2 * width), result element p (p < pairs, element k occupying bits k*width upward) equals src_a element 2p + odd_sel.
- R3: Result element pairs + p equals src_b element 2p + odd_sel, for p < pairs.
- R4: odd_sel = 0 picks the even-indexed source elements and odd_sel = 1 picks the odd-indexed ones.
- R5: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R6: out_undef is high together with out_valid when VL < 2 * width. A request with wide_form = 0 never raises it, since VL is at least 128.
- R7: While out_undef is high, result is all zeros.
- R8: result keeps its value in every cycle that follows a cycle with in_valid low.
- R9: While rst is high, and in the first cycle after it, out_valid and out_undef are low and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | VL | First source operand, feeds the lower half |
| src_b | input | VL | Second source operand, feeds the upper half |
| size_code | input | 2 | Element width code when wide_form is 0 |
| wide_form | input | 1 | Selects fixed 128-bit elements |
| odd_sel | input | 1 | 0 selects even elements, 1 selects odd elements |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_undef | output | 1 | Length too short for the chosen width |
| result | output | VL | Packed destination vector |

## Verification
On every cycle the assertions check the valid timing, the pairing of the undefined flag with valid and with a zero result, the holding of the result between requests, and two element positions at byte width: the lowest result element and the highest. Full element placement for all widths, both part selects and three vector lengths (128, 256, 512) is shown only by the bench scenarios. These compare every result bit against a model of the pair loop. The undefined case for the wide form is reached only through the 128-bit instance in the bench.

// File: rtl/vunzip_pkg.sv
package vunzip_pkg;

  localparam int NUM_WIDTHS = 5;
  localparam int WIDE_BITS  = 128;

  typedef enum logic [2:0] {
    EW_8   = 3'd0,
    EW_16  = 3'd1,
    EW_32  = 3'd2,
    EW_64  = 3'd3,
    EW_128 = 3'd4
  } ewidth_e;

  function automatic int ewidth_bits(input ewidth_e w);
    return 8 << int'(w);
  endfunction

endpackage

// File: rtl/vunzip_decode.sv
module vunzip_decode
  import vunzip_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic [1:0] size_code,
  input  logic       wide_form,
  output ewidth_e    width_sel,
  output logic       too_short
);

  always_comb begin
    if (wide_form) width_sel = EW_128;
    else           width_sel = ewidth_e'({1'b0, size_code});
    too_short = (VL < 2 * ewidth_bits(width_sel));
  end

endmodule

// File: rtl/vunzip_pack.sv
module vunzip_pack #(
  parameter int VL  = 256,
  parameter int ESZ = 8
) (
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  input  logic          odd_sel,
  output logic [VL-1:0] packed_out
);

  localparam int PAIRS = VL / (2 * ESZ);

  generate
    if (PAIRS == 0) begin : g_empty
      assign packed_out = '0;
    end else begin : g_pairs
      for (genvar p = 0; p < PAIRS; p++) begin : g_pick
        assign packed_out[p*ESZ +: ESZ] =
          odd_sel ? src_a[(2*p+1)*ESZ +: ESZ] : src_a[(2*p)*ESZ +: ESZ];
        assign packed_out[(PAIRS+p)*ESZ +: ESZ] =
          odd_sel ? src_b[(2*p+1)*ESZ +: ESZ] : src_b[(2*p)*ESZ +: ESZ];
      end
    end
  endgenerate

endmodule

// File: rtl/vunzip_select.sv
module vunzip_select
  import vunzip_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic [VL-1:0] cand [NUM_WIDTHS],
  input  ewidth_e       width_sel,
  output logic [VL-1:0] picked
);

  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_WIDTHS; k++) begin
      if (int'(width_sel) == k) picked = cand[k];
    end
  end

endmodule

// File: rtl/vec_unzip_unit.sv
module vec_unzip_unit
  import vunzip_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  input  logic [1:0]    size_code,
  input  logic          wide_form,
  input  logic          odd_sel,
  output logic          out_valid,
  output logic          out_undef,
  output logic [VL-1:0] result
);

  ewidth_e       width_sel;
  logic          too_short;
  logic [VL-1:0] cand [NUM_WIDTHS];
  logic [VL-1:0] picked;

  vunzip_decode #(.VL(VL)) u_dec (
    .size_code (size_code),
    .wide_form (wide_form),
    .width_sel (width_sel),
    .too_short (too_short)
  );

  generate
    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
      vunzip_pack #(.VL(VL), .ESZ(8 << k)) u_pack (
        .src_a      (src_a),
        .src_b      (src_b),
        .odd_sel    (odd_sel),
        .packed_out (cand[k])
      );
    end
  endgenerate

  vunzip_select #(.VL(VL)) u_sel (
    .cand      (cand),
    .width_sel (width_sel),
    .picked    (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      out_undef <= in_valid & too_short;
      if (in_valid) result <= too_short ? '0 : picked;
    end
  end

endmodule

// File: rtl/vunzip_checker.sv
module vunzip_checker #(
  parameter int VL = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [VL-1:0] src_a,
  input logic [VL-1:0] src_b,
  input logic [1:0]    size_code,
  input logic          wide_form,
  input logic          odd_sel,
  input logic          out_valid,
  input logic          out_undef,
  input logic [VL-1:0] result
);

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_undef_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> out_valid);

  p_no_undef_narrow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_form) |=> !out_undef);

  p_undef_zero_r7: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> (result == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_first_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_form && size_code == 2'd0) |=>
      (result[7:0] == ($past(odd_sel) ? $past(src_a[15:8]) : $past(src_a[7:0]))));

  p_last_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_form && size_code == 2'd0) |=>
      (result[VL-1 -: 8] == ($past(odd_sel) ? $past(src_b[VL-1 -: 8])
                                            : $past(src_b[VL-9 -: 8]))));

endmodule

bind vec_unzip_unit vunzip_checker #(.VL(VL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .src_a     (src_a),
  .src_b     (src_b),
  .size_code (size_code),
  .wide_form (wide_form),
  .odd_sel   (odd_sel),
  .out_valid (out_valid),
  .out_undef (out_undef),
  .result    (result)
);

// File: tb/vec_unzip_unit_test.sv
`timescale 1ns/1ps
module vec_unzip_unit_test;

  localparam int MAXW = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [MAXW-1:0] a = '0, b = '0;
  logic [1:0] size_code = 2'd0;
  logic wide_form = 1'b0;
  logic odd_sel = 1'b0;

  logic v256, u256, v512, u512, v128, u128;
  logic [255:0] r256;
  logic [511:0] r512;
  logic [127:0] r128;

  int n_cmp = 0;
  int n_bad = 0;
  logic [MAXW-1:0] last256, last512, last128;

  always #2.5 clk = ~clk;

  vec_unzip_unit #(.VL(256)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(a[255:0]), .src_b(b[255:0]),
    .size_code(size_code), .wide_form(wide_form), .odd_sel(odd_sel),
    .out_valid(v256), .out_undef(u256), .result(r256));

  vec_unzip_unit #(.VL(512)) uut_w (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(a), .src_b(b),
    .size_code(size_code), .wide_form(wide_form), .odd_sel(odd_sel),
    .out_valid(v512), .out_undef(u512), .result(r512));

  vec_unzip_unit #(.VL(128)) uut_n (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(a[127:0]), .src_b(b[127:0]),
    .size_code(size_code), .wide_form(wide_form), .odd_sel(odd_sel),
    .out_valid(v128), .out_undef(u128), .result(r128));

  function automatic logic [MAXW-1:0] model(input int vl, input logic [MAXW-1:0] sa,
      input logic [MAXW-1:0] sb, input int ew, input bit odd);
    logic [MAXW-1:0] r = '0;
    int pairs = vl / (2 * ew);
    for (int p = 0; p < pairs; p++) begin
      for (int i = 0; i < ew; i++) begin
        r[p*ew + i]         = sa[(2*p + int'(odd))*ew + i];
        r[(pairs+p)*ew + i] = sb[(2*p + int'(odd))*ew + i];
      end
    end
    return r;
  endfunction

  function automatic logic [MAXW-1:0] rnd_vec();
    logic [MAXW-1:0] v;
    for (int w = 0; w < MAXW/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [MAXW-1:0] act,
                       input logic [MAXW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [MAXW-1:0] sa, input logic [MAXW-1:0] sb,
                       input logic [1:0] sc, input bit wide, input bit odd, input string req);
    int ew;
    logic [MAXW-1:0] e256, e512, e128;
    @(negedge clk);
    // previous cycle had in_valid low: no valid pulse, result held (R5, R8)
    check(v256 == 1'b0 && v512 == 1'b0 && v128 == 1'b0, "R5 pulse", {v256, v512, v128}, '0);
    check({256'd0, r256} == last256 && r512 == last512 && {384'd0, r128} == last128,
          "R8 hold", {256'd0, r256}, last256);
    a = sa; b = sb; size_code = sc; wide_form = wide; odd_sel = odd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    a = rnd_vec(); b = rnd_vec(); size_code = 2'($urandom); odd_sel = 1'($urandom);
    ew = wide ? 128 : (8 << sc);
    e256 = model(256, sa, sb, ew, odd);
    e512 = model(512, sa, sb, ew, odd);
    e128 = (128 < 2*ew) ? '0 : model(128, sa, sb, ew, odd);
    check(v256 && v512 && v128, {"R5 valid ", req}, {v256, v512, v128}, 3'b111);
    check({256'd0, r256} == e256, {"R2 R3 vl256 ", req}, {256'd0, r256}, e256);
    check(r512 == e512, {"R2 R3 vl512 ", req}, r512, e512);
    check({384'd0, r128} == e128, {"R2 R3 R7 vl128 ", req}, {384'd0, r128}, e128);
    check(u256 == 1'b0 && u512 == 1'b0, {"R6 no undef ", req}, {u256, u512}, '0);
    check(u128 == (128 < 2*ew), {"R6 undef vl128 ", req}, u128, (128 < 2*ew));
    last256 = {256'd0, r256}; last512 = r512; last128 = {384'd0, r128};
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [MAXW-1:0] ramp;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < MAXW/8; i++) ramp[i*8 +: 8] = 8'(i);
    repeat (4) @(negedge clk);
    // R9: reset state while rst is held
    check(!v256 && !v512 && !v128 && !u256 && !u512 && !u128, "R9 flags",
          {v256, v512, v128, u256, u512, u128}, '0);
    check(r256 == '0 && r512 == '0 && r128 == '0, "R9 result", r512, '0);
    rst = 1'b0;
    last256 = '0; last512 = '0; last128 = '0;

    // R1 and R4: every size code with both parts on a ramp pattern
    for (int s = 0; s < 4; s++) begin
      do_op(ramp, ~ramp, 2'(s), 1'b0, 1'b0, "R1 R4 even");
      do_op(ramp, ~ramp, 2'(s), 1'b0, 1'b1, "R1 R4 odd");
    end
    // R1: wide form ignores size_code; R6 R7 on the 128-bit instance
    do_op(ramp, ~ramp, 2'd0, 1'b1, 1'b0, "R1 wide even code0");
    do_op(ramp, ~ramp, 2'd3, 1'b1, 1'b1, "R1 wide odd code3");
    do_op('1, '1, 2'd2, 1'b1, 1'b0, "R7 wide ones");
    do_op('0, '1, 2'd0, 1'b0, 1'b1, "R3 split");

    for (int n = 0; n < 300; n++)
      do_op(rnd_vec(), rnd_vec(), 2'($urandom), 1'(($urandom % 5) == 0),
            1'($urandom), "random");

    @(negedge clk);
    check(!v256 && !v512 && !v128, "R5 final idle", {v256, v512, v128}, '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule